// File: doc/BRIEF.md
# General-Purpose I/O Port with Chip-Wide Drive Gate

This block is an eight-bit general-purpose I/O port that sits on a simple single-cycle register bus. Software chooses, bit by bit, whether a pin is an input or an output through a direction register. It supplies the levels that output pins present through a data register. Each pin leaves the block as a value line plus a drive-enable line, and the pad ring above it forms the tri-state buffer.

A single active-low gate pin, shared across the chip, can release every output-configured bit at once. While the gate pin is high, no bit drives, but the registers keep their contents. When the gate pin returns low, the outputs come back with whatever the data register holds at that point. Input-configured bits ignore the gate completely.

Pin levels and the gate level both enter the clock domain through two-flop synchronizers. A read of the data address combines two sources: the synchronized pin level for input bits and the register value for output bits. A read-only status location reports the synchronized gate level in its top bit.

Top module: `gpio_gate_port`

## Requirements
- R1: After reset the data and direction registers hold 0x00, every drive-enable output is 0, the pin value outputs are 0x00, and the read-data bus is 0x00.
- R2: Bit i of the direction register (address 1) selects pin i as an output when 1 and as an input when 0, independently for each bit. A write is readable at the same address.
- R3: While the synchronized gate pin is low, the drive-enable output of each bit equals its direction bit, and the pin value outputs equal the data register (address 0).
- R4: While the synchronized gate pin is high, every drive-enable output is 0, whatever the direction register holds.
- R5: Input-configured bits are unaffected by the gate pin: a read of address 0 returns their pin levels whether the gate is high or low.
- R6: A read of address 0 returns, for each bit, the data register value if the bit is an output and the synchronized pin level if it is an input.
- R7: An input pin change is seen by a read that the bus samples on the third rising edge after the change. A read sampled on the second edge still returns the old level.
- R8: A read of the status location (address 2) returns the synchronized gate level in bit 7 and 0 in bits 6..0. Writes to address 2 change nothing.
- R9: A gate-pin change reaches the drive-enable outputs on the third rising edge after the change. They still show the old state after the second.
- R10: Read data appears on the read-data bus one cycle after the read is sampled and holds its value until the next read.
- R11: Data written while the gate is high is kept and is driven once the gate returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels as seen at the pads |
| pad_out | output | 8 | Value presented to each pad driver |
| pad_drive | output | 8 | Per-bit drive enable, 1 = pad driven |
| drv_gate_n | input | 1 | Chip-wide active-low drive gate |

## Verification
Two events can land on the same edge: a direction-register write from the bus, and the synchronized gate level flipping. The bench provokes this by lowering the gate pin at a falling edge and timing a direction write so that it is sampled on the edge where the gate's second synchronizer stage updates. The drive-enable outputs must read 0x00 after that edge, because the old gate state still applies. After the following edge they must equal the newly written direction, so both changes take effect together with neither lost.

// File: rtl/gpio_gate_pkg.sv
package gpio_gate_pkg;

  // Register locations on the port's bus
  typedef enum logic [1:0] {
    LOC_DATA = 2'd0,
    LOC_DIR  = 2'd1,
    LOC_STAT = 2'd2,
    LOC_NONE = 2'd3
  } loc_e;

  localparam int ADDR_W = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[LAST];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_gate_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pin_sync_i,
  input  logic              gate_n_sync_i,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      rdata_q
);

  localparam int STAT_BIT = W - 1;

  logic wr_fire, rd_fire;
  loc_e loc;
  logic [W-1:0] merged;
  logic [W-1:0] status_vec;

  assign wr_fire = sel_i & wr_i;
  assign rd_fire = sel_i & ~wr_i;
  assign loc     = loc_e'(addr_i);

  // Output bits read back the register, input bits read the pin
  assign merged = (dir_q & data_q) | (~dir_q & pin_sync_i);

  always_comb begin
    status_vec           = '0;
    status_vec[STAT_BIT] = gate_n_sync_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr_fire) begin
      case (loc)
        LOC_DATA: data_q <= wdata_i;
        LOC_DIR:  dir_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_fire) begin
      case (loc)
        LOC_DATA: rdata_q <= merged;
        LOC_DIR:  rdata_q <= dir_q;
        LOC_STAT: rdata_q <= status_vec;
        default:  rdata_q <= '0;
      endcase
    end
  end

  // R2: a direction write lands in the register
  a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && loc == LOC_DIR) |=> (dir_q == $past(wdata_i)));

  // R8: status read carries nothing below the gate bit
  a_r8_stat_low_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && loc == LOC_STAT) |=> (rdata_q[STAT_BIT-1:0] == '0));

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rdata_q));

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] dir_i,
  input  logic         gate_n_sync_i,
  output logic [W-1:0] pad_out_q,
  output logic [W-1:0] pad_drive_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_q   <= '0;
      pad_drive_q <= '0;
    end else begin
      pad_out_q <= data_i;
      for (int i = 0; i < W; i++) begin
        pad_drive_q[i] <= dir_i[i] & ~gate_n_sync_i;
      end
    end
  end

  // R4: gate high releases every pad on the next edge
  a_r4_gate_releases: assert property (@(posedge clk) disable iff (rst)
    gate_n_sync_i |=> (pad_drive_q == '0));

  // R3: gate low makes drive follow direction
  a_r3_drive_follows_dir: assert property (@(posedge clk) disable iff (rst)
    !gate_n_sync_i |=> (pad_drive_q == $past(dir_i)));

  // R3: pad value follows the data register
  a_r3_out_follows_data: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_out_q == $past(data_i)));

endmodule

// File: rtl/gpio_gate_port.sv
module gpio_gate_port
  import gpio_gate_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_drive,
  input  logic              drv_gate_n
);

  logic [W-1:0] pin_sync;
  logic         gate_n_sync;
  logic [W-1:0] data_q, dir_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .din (pad_in),
    .dout(pin_sync)
  );

  // Gate synchronizer resets to the released state
  gpio_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gate_sync (
    .clk (clk),
    .rst (rst),
    .din (drv_gate_n),
    .dout(gate_n_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .sel_i        (bus_sel),
    .wr_i         (bus_wr),
    .addr_i       (bus_addr),
    .wdata_i      (bus_wdata),
    .pin_sync_i   (pin_sync),
    .gate_n_sync_i(gate_n_sync),
    .data_q       (data_q),
    .dir_q        (dir_q),
    .rdata_q      (bus_rdata)
  );

  gpio_drive #(.W(W)) u_drive (
    .clk          (clk),
    .rst          (rst),
    .data_i       (data_q),
    .dir_i        (dir_q),
    .gate_n_sync_i(gate_n_sync),
    .pad_out_q    (pad_out),
    .pad_drive_q  (pad_drive)
  );

  // R4: a pad is never driven unless it is an output
  a_r4_drive_subset_dir: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_drive & ~$past(dir_q)) == '0));

endmodule

// File: tb/sim_gpio_gate_port.sv
module sim_gpio_gate_port;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pad_in, pad_out, pad_drive;
  logic       drv_gate_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_gate_port u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_drive(pad_drive),
    .drv_gate_n(drv_gate_n)
  );

  // {dir, data, pins, gate_n, exp_drive, exp_out, exp_read}
  localparam int NV = 8;
  localparam logic [48:0] VEC [NV] = '{
    {8'hFF, 8'hA5, 8'h00, 1'b0, 8'hFF, 8'hA5, 8'hA5},
    {8'h00, 8'h3C, 8'h96, 1'b0, 8'h00, 8'h3C, 8'h96},
    {8'hF0, 8'h5A, 8'h0F, 1'b0, 8'hF0, 8'h5A, 8'h5F},
    {8'hF0, 8'h5A, 8'h0F, 1'b1, 8'h00, 8'h5A, 8'h5F},
    {8'h0F, 8'hC3, 8'hA5, 1'b1, 8'h00, 8'hC3, 8'hA3},
    {8'h81, 8'hFF, 8'h00, 1'b0, 8'h81, 8'hFF, 8'h81},
    {8'h55, 8'h00, 8'hFF, 1'b0, 8'h55, 8'h00, 8'hAA},
    {8'h55, 8'h00, 8'hFF, 1'b1, 8'h00, 8'h00, 8'hAA}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] rd;
    rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pad_in = 8'h00; drv_gate_n = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 drive", pad_drive, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    bus_read(2'd1, rd); chk("R1 dir", rd, 8'h00);
    settle();
    bus_read(2'd0, rd); chk("R1 data", rd, 8'h00);

    // Vector walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      bus_write(2'd1, VEC[i][48:41]);
      bus_write(2'd0, VEC[i][40:33]);
      pad_in = VEC[i][32:25];
      drv_gate_n = VEC[i][24];
      settle();
      chk(VEC[i][24] ? "R4 drive" : "R3 drive", pad_drive, VEC[i][23:16]);
      chk("R3 out", pad_out, VEC[i][15:8]);
      bus_read(2'd0, rd); chk("R6 R5 read", rd, VEC[i][7:0]);
      bus_read(2'd1, rd); chk("R2 dir readback", rd, VEC[i][48:41]);
      bus_read(2'd2, rd); chk("R8 status", rd, {VEC[i][24], 7'h00});
    end

    // R7 input synchronizer latency
    drv_gate_n = 1'b0;
    bus_write(2'd1, 8'h00);
    pad_in = 8'h00;
    settle();
    @(negedge clk); pad_in = 8'hFF;
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
    @(negedge clk); chk("R7 second edge old", bus_rdata, 8'h00);
    @(negedge clk); chk("R7 third edge new", bus_rdata, 8'hFF);
    bus_sel = 1'b0;

    // R10 hold between reads
    pad_in = 8'h11;
    settle();
    chk("R10 hold", bus_rdata, 8'hFF);

    // R9 gate synchronizer latency
    bus_write(2'd1, 8'hFF);
    settle();
    @(negedge clk); drv_gate_n = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R9 second edge old", pad_drive, 8'hFF);
    @(negedge clk); chk("R9 third edge new", pad_drive, 8'h00);

    // R11 data written while gated is driven afterwards
    bus_write(2'd0, 8'h77);
    settle();
    chk("R11 gated drive", pad_drive, 8'h00);
    drv_gate_n = 1'b0;
    settle();
    chk("R11 released drive", pad_drive, 8'hFF);
    chk("R11 released out", pad_out, 8'h77);

    // R8 writes to status are ignored
    drv_gate_n = 1'b1;
    settle();
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, rd); chk("R8 write ignored high", rd, 8'h80);
    drv_gate_n = 1'b0;
    settle();
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, rd); chk("R8 write ignored low", rd, 8'h00);
    bus_read(2'd0, rd); chk("R8 data untouched", rd, 8'h77);
    bus_read(2'd1, rd); chk("R8 dir untouched", rd, 8'hFF);

    // Concurrent: direction write and gate release on the same edge (R2 R3)
    bus_write(2'd1, 8'h00);
    drv_gate_n = 1'b1;
    settle();
    @(negedge clk); drv_gate_n = 1'b0;
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h0F;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R4 concurrent old gate", pad_drive, 8'h00);
    @(negedge clk); chk("R3 concurrent both applied", pad_drive, 8'h0F);

    // R1 reset again clears registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 re-reset drive", pad_drive, 8'h00);
    bus_read(2'd1, rd); chk("R1 re-reset dir", rd, 8'h00);

    finish_up();
  end

endmodule